// File: doc/BRIEF.md
# Two-Level Privileged Control Register File

This block holds the control and status registers a 32-bit core needs to run at machine level and at supervisor level: status, interrupt enable, interrupt pending, trap vector, trap cause, exception PC, trap value and scratch for each level, plus the ISA description register. Supervisor status, enable and pending have no storage of their own. Each is a masked window onto the matching machine register. A read through the window hides the machine-only bits. A write through the window touches only the bits the mask lets through.

Software reaches every register through a single port addressed by a 12-bit register number. Reads are combinational. A write lands on the rising clock edge while the write strobe is high. Any number outside the implemented set raises an illegal-access flag, reads as zero and changes nothing.

Two interrupt lines, timer and external, are combined with the machine enable bits to form request outputs. Each request is also reported as taken when the global machine interrupt enable is set. Trap entry, privilege changes and instruction decode belong to other blocks.

Top module: `priv_csr_file`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), machine status, enable, pending, cause and trap value read as zero, and the machine trap vector reads 0x80000020.
- R2: The enable and pending registers use these bit positions: supervisor software 1, machine software 3, supervisor timer 5, machine timer 7, supervisor external 9, machine external 11. In the status register the global machine interrupt enable is bit 3 and the supervisor interrupt enable is bit 1.
- R3: A read of the supervisor status register (0x100) returns machine status AND 0x133.
- R4: A read of supervisor enable (0x104) or supervisor pending (0x144) returns machine enable or machine pending AND 0x333.
- R5: A write to 0x100 sets machine status to (old AND NOT 0x133) OR (wdata AND 0x133).
- R6: A write to 0x104 or 0x144 sets machine enable or machine pending to (old AND NOT 0x333) OR (wdata AND 0x333).
- R7: A write to any machine register, or to supervisor trap vector, cause, trap value, exception PC or scratch, replaces the whole 32-bit value. A later read returns exactly the written value, and no other register changes.
- R8: The implemented numbers are 0x100, 0x104, 0x105, 0x140, 0x141, 0x142, 0x143, 0x144 (supervisor status, enable, vector, scratch, exception PC, cause, trap value, pending) and 0x300, 0x301, 0x304, 0x305, 0x340, 0x341, 0x342, 0x343, 0x344 (machine status, ISA, enable, vector, scratch, exception PC, cause, trap value, pending).
- R9: For any other number, csr_illegal is high, csr_rdata is zero, and a write changes no register.
- R10: A read in the same cycle as a write to the same register returns the old value. The new value is visible after the rising edge.
- R11: mtimer_req equals machine-enable bit 7 AND irq_timer. mtimer_take equals mtimer_req AND status bit 3.
- R12: mext_req equals machine-enable bit 11 AND irq_ext. mext_take equals mext_req AND status bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | Register number for the read and the write |
| csr_we | input | 1 | Write strobe, sampled at the rising edge |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data |
| csr_illegal | output | 1 | High when csr_addr is not implemented |
| irq_timer | input | 1 | Machine timer interrupt line |
| irq_ext | input | 1 | Machine external interrupt line |
| mtimer_req | output | 1 | Timer interrupt requested |
| mtimer_take | output | 1 | Timer request allowed by global enable |
| mext_req | output | 1 | External interrupt requested |
| mext_take | output | 1 | External request allowed by global enable |

## Verification
The bench builds the block with its default 32-bit width and the default trap-vector and ISA reset values. Because the register number is only 12 bits wide, the bench sweeps every one of the 4096 numbers, so the legal map and the illegal flag are covered completely. Each window is then exercised with every pair from a set of bit patterns written through the machine and supervisor sides, which covers masked and unmasked bits in both directions. The interrupt outputs are checked for all eight combinations of enable bit, input line and global enable.

// File: rtl/priv_csr_pkg.sv
// Package: register numbers, window masks and bit positions shared by the
// privileged register file and its submodules.
package priv_csr_pkg;

    localparam int NUM_CSR = 17;

    // Index of each register inside the one-hot select vector
    localparam int ID_SSTATUS  = 0;
    localparam int ID_SIE      = 1;
    localparam int ID_STVEC    = 2;
    localparam int ID_SSCRATCH = 3;
    localparam int ID_SEPC     = 4;
    localparam int ID_SCAUSE   = 5;
    localparam int ID_STVAL    = 6;
    localparam int ID_SIP      = 7;
    localparam int ID_MSTATUS  = 8;
    localparam int ID_MISA     = 9;
    localparam int ID_MIE      = 10;
    localparam int ID_MTVEC    = 11;
    localparam int ID_MSCRATCH = 12;
    localparam int ID_MEPC     = 13;
    localparam int ID_MCAUSE   = 14;
    localparam int ID_MTVAL    = 15;
    localparam int ID_MIP      = 16;

    // Window masks applied to the shared machine registers
    localparam logic [31:0] STATUS_WIN_MASK = 32'h0000_0133;
    localparam logic [31:0] INT_WIN_MASK    = 32'h0000_0333;

    // Bit positions the interrupt logic decodes
    localparam int ST_MIE_BIT   = 3;
    localparam int ST_SIE_BIT   = 1;
    localparam int IRQ_MTIM_BIT = 7;
    localparam int IRQ_MEXT_BIT = 11;

    // Register number for a select index
    function automatic logic [11:0] csr_number(input int id);
        case (id)
            ID_SSTATUS:  return 12'h100;
            ID_SIE:      return 12'h104;
            ID_STVEC:    return 12'h105;
            ID_SSCRATCH: return 12'h140;
            ID_SEPC:     return 12'h141;
            ID_SCAUSE:   return 12'h142;
            ID_STVAL:    return 12'h143;
            ID_SIP:      return 12'h144;
            ID_MSTATUS:  return 12'h300;
            ID_MISA:     return 12'h301;
            ID_MIE:      return 12'h304;
            ID_MTVEC:    return 12'h305;
            ID_MSCRATCH: return 12'h340;
            ID_MEPC:     return 12'h341;
            ID_MCAUSE:   return 12'h342;
            ID_MTVAL:    return 12'h343;
            default:     return 12'h344;
        endcase
    endfunction

endpackage

// File: rtl/priv_csr_decode.sv
// Address decoder: turns a 12-bit register number into a one-hot select over
// the implemented registers and a legal flag.
// Assumes every entry of csr_number() is distinct.
module priv_csr_decode
    import priv_csr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM    = NUM_CSR
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM-1:0]    sel,
    output logic              legal
);

    // One comparator per implemented register
    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign sel[g] = (addr == ADDR_W'(csr_number(g)));
    end

    // Any hit makes the access legal
    assign legal = |sel;

endmodule

// File: rtl/priv_csr_window.sv
// Masked window: shows the permitted bits of a shared register and forms the
// merged value a write through the window would store.
// Assumes MASK fits in W bits.
module priv_csr_window #(
    parameter int          W    = 32,
    parameter logic [31:0] MASK = 32'h0
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] view,
    output logic [W-1:0] merged
);

    localparam logic [W-1:0] M = W'(MASK);

    // Read side hides the bits outside the mask
    assign view   = base & M;
    // Write side keeps the bits outside the mask
    assign merged = (base & ~M) | (wdata & M);

endmodule

// File: rtl/priv_csr_irq.sv
// Interrupt request logic: combines the machine enable bits with the timer and
// external lines, then gates each request with the global machine enable.
// Assumes W is wide enough to hold IRQ_MEXT_BIT.
module priv_csr_irq
    import priv_csr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] ie_q,
    input  logic [W-1:0] status_q,
    input  logic         timer_line,
    input  logic         ext_line,
    output logic         timer_req,
    output logic         timer_take,
    output logic         ext_req,
    output logic         ext_take
);

    logic glob_en;

    // Requests and their gating by the global enable
    always_comb begin
        glob_en    = status_q[ST_MIE_BIT];
        timer_req  = ie_q[IRQ_MTIM_BIT] & timer_line;
        ext_req    = ie_q[IRQ_MEXT_BIT] & ext_line;
        timer_take = timer_req & glob_en;
        ext_take   = ext_req & glob_en;
    end

endmodule

// File: rtl/priv_csr_file.sv
// Privileged register file: storage for machine and supervisor registers,
// supervisor status/enable/pending as masked windows onto machine storage,
// combinational read, write on the rising edge, illegal-number flag and
// interrupt request outputs. Synchronous active-low reset.
module priv_csr_file
    import priv_csr_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          ADDR_W      = 12,
    parameter logic [31:0] MTVEC_RESET = 32'h8000_0020,
    parameter logic [31:0] MISA_RESET  = 32'h4014_1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    input  logic              irq_timer,
    input  logic              irq_ext,
    output logic              mtimer_req,
    output logic              mtimer_take,
    output logic              mext_req,
    output logic              mext_take
);

    localparam int NWIN = 3;   // status, enable, pending windows

    logic [NUM_CSR-1:0] sel;
    logic               legal;
    logic               wr_hit;

    logic [XLEN-1:0] mstatus_q, mie_q, mip_q, mtvec_q, mcause_q, mtval_q;
    logic [XLEN-1:0] mepc_q, mscratch_q, misa_q;
    logic [XLEN-1:0] stvec_q, scause_q, stval_q, sepc_q, sscratch_q;

    logic [XLEN-1:0] win_base  [NWIN];
    logic [XLEN-1:0] win_view  [NWIN];
    logic [XLEN-1:0] win_merge [NWIN];
    logic [XLEN-1:0] rd_val    [NUM_CSR];

    priv_csr_decode #(.ADDR_W(ADDR_W), .NUM(NUM_CSR)) u_decode (
        .addr  (csr_addr),
        .sel   (sel),
        .legal (legal)
    );

    assign csr_illegal = ~legal;
    assign wr_hit      = csr_we & legal;

    assign win_base[0] = mstatus_q;
    assign win_base[1] = mie_q;
    assign win_base[2] = mip_q;

    // One masked window per shared machine register
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [31:0] WMASK = (w == 0) ? STATUS_WIN_MASK : INT_WIN_MASK;
        priv_csr_window #(.W(XLEN), .MASK(WMASK)) u_win (
            .base   (win_base[w]),
            .wdata  (csr_wdata),
            .view   (win_view[w]),
            .merged (win_merge[w])
        );
    end

    // Read values indexed by select position
    always_comb begin
        rd_val[ID_SSTATUS]  = win_view[0];
        rd_val[ID_SIE]      = win_view[1];
        rd_val[ID_SIP]      = win_view[2];
        rd_val[ID_STVEC]    = stvec_q;
        rd_val[ID_SSCRATCH] = sscratch_q;
        rd_val[ID_SEPC]     = sepc_q;
        rd_val[ID_SCAUSE]   = scause_q;
        rd_val[ID_STVAL]    = stval_q;
        rd_val[ID_MSTATUS]  = mstatus_q;
        rd_val[ID_MISA]     = misa_q;
        rd_val[ID_MIE]      = mie_q;
        rd_val[ID_MTVEC]    = mtvec_q;
        rd_val[ID_MSCRATCH] = mscratch_q;
        rd_val[ID_MEPC]     = mepc_q;
        rd_val[ID_MCAUSE]   = mcause_q;
        rd_val[ID_MTVAL]    = mtval_q;
        rd_val[ID_MIP]      = mip_q;
    end

    // AND-OR read mux driven by the one-hot select
    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            csr_rdata = csr_rdata | (rd_val[i] & {XLEN{sel[i]}});
        end
    end

    // Shared machine registers written whole or through their window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mstatus_q <= '0;
            mie_q     <= '0;
            mip_q     <= '0;
        end else if (wr_hit) begin
            if (sel[ID_MSTATUS]) mstatus_q <= csr_wdata;
            if (sel[ID_SSTATUS]) mstatus_q <= win_merge[0];
            if (sel[ID_MIE])     mie_q     <= csr_wdata;
            if (sel[ID_SIE])     mie_q     <= win_merge[1];
            if (sel[ID_MIP])     mip_q     <= csr_wdata;
            if (sel[ID_SIP])     mip_q     <= win_merge[2];
        end
    end

    // Remaining registers take the full write value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mtvec_q    <= XLEN'(MTVEC_RESET);
            misa_q     <= XLEN'(MISA_RESET);
            mcause_q   <= '0;
            mtval_q    <= '0;
            mepc_q     <= '0;
            mscratch_q <= '0;
            stvec_q    <= '0;
            scause_q   <= '0;
            stval_q    <= '0;
            sepc_q     <= '0;
            sscratch_q <= '0;
        end else if (wr_hit) begin
            if (sel[ID_MTVEC])    mtvec_q    <= csr_wdata;
            if (sel[ID_MISA])     misa_q     <= csr_wdata;
            if (sel[ID_MCAUSE])   mcause_q   <= csr_wdata;
            if (sel[ID_MTVAL])    mtval_q    <= csr_wdata;
            if (sel[ID_MEPC])     mepc_q     <= csr_wdata;
            if (sel[ID_MSCRATCH]) mscratch_q <= csr_wdata;
            if (sel[ID_STVEC])    stvec_q    <= csr_wdata;
            if (sel[ID_SCAUSE])   scause_q   <= csr_wdata;
            if (sel[ID_STVAL])    stval_q    <= csr_wdata;
            if (sel[ID_SEPC])     sepc_q     <= csr_wdata;
            if (sel[ID_SSCRATCH]) sscratch_q <= csr_wdata;
        end
    end

    priv_csr_irq #(.W(XLEN)) u_irq (
        .ie_q       (mie_q),
        .status_q   (mstatus_q),
        .timer_line (irq_timer),
        .ext_line   (irq_ext),
        .timer_req  (mtimer_req),
        .timer_take (mtimer_take),
        .ext_req    (mext_req),
        .ext_take   (mext_take)
    );

    // Decoder never selects two registers at once (R8)
    p_onehot_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // Status window write leaves machine-only bits alone (R5)
    p_status_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel[ID_SSTATUS]) |=>
        ((mstatus_q & ~XLEN'(STATUS_WIN_MASK)) == $past(mstatus_q & ~XLEN'(STATUS_WIN_MASK))));

    // Enable window write leaves machine-only bits alone (R6)
    p_enable_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel[ID_SIE]) |=>
        ((mie_q & ~XLEN'(INT_WIN_MASK)) == $past(mie_q & ~XLEN'(INT_WIN_MASK))));

    // Full write of machine scratch stores the data unchanged (R7)
    p_full_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel[ID_MSCRATCH]) |=> (mscratch_q == $past(csr_wdata)));

    // Write to an unknown number leaves every register as it was (R9)
    p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !legal) |=>
        $stable({mstatus_q, mie_q, mip_q, mtvec_q, mcause_q, mtval_q, mepc_q,
                 mscratch_q, misa_q, stvec_q, scause_q, stval_q, sepc_q, sscratch_q}));

endmodule

// File: tb/test_priv_csr_file.sv
// Self-checking bench for priv_csr_file: full address sweep, window pattern
// pairs, full-write patterns and all interrupt input combinations.
module test_priv_csr_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        irq_timer = 1'b0;
    logic        irq_ext = 1'b0;
    logic        mtimer_req, mtimer_take, mext_req, mext_take;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] SMASK = 32'h133;
    localparam logic [31:0] IMASK = 32'h333;

    priv_csr_file i_priv_csr_file (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_addr    (csr_addr),
        .csr_we      (csr_we),
        .csr_wdata   (csr_wdata),
        .csr_rdata   (csr_rdata),
        .csr_illegal (csr_illegal),
        .irq_timer   (irq_timer),
        .irq_ext     (irq_ext),
        .mtimer_req  (mtimer_req),
        .mtimer_take (mtimer_take),
        .mext_req    (mext_req),
        .mext_take   (mext_take)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        csr_we = 1'b0; csr_addr = a;
        #1 d = csr_rdata;
    endtask

    function automatic bit known(input logic [11:0] a);
        case (a)
            12'h100, 12'h104, 12'h105, 12'h140, 12'h141, 12'h142, 12'h143, 12'h144,
            12'h300, 12'h301, 12'h304, 12'h305, 12'h340, 12'h341, 12'h342, 12'h343,
            12'h344: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Registers replaced whole on write (R7)
    logic [11:0] full_list [14] = '{12'h300, 12'h301, 12'h304, 12'h305, 12'h340,
        12'h341, 12'h342, 12'h343, 12'h344, 12'h105, 12'h140, 12'h141, 12'h142, 12'h143};
    logic [31:0] pats [5] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5,
        32'h5A5A_5A5A, 32'h1234_5678};

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(12'h300, v); chk("R1", "mstatus reset", v, 32'h0);
        rd(12'h304, v); chk("R1", "mie reset", v, 32'h0);
        rd(12'h344, v); chk("R1", "mip reset", v, 32'h0);
        rd(12'h342, v); chk("R1", "mcause reset", v, 32'h0);
        rd(12'h343, v); chk("R1", "mtval reset", v, 32'h0);
        rd(12'h305, v); chk("R1", "mtvec reset", v, 32'h8000_0020);

        // R8 / R9: every register number
        for (int a = 0; a < 4096; a++) begin
            csr_addr = 12'(a);
            #1;
            chk("R8", $sformatf("illegal flag @%03h", a), {31'b0, csr_illegal},
                {31'b0, ~known(12'(a))});
            if (!known(12'(a))) chk("R9", $sformatf("rdata @%03h", a), csr_rdata, 32'h0);
        end

        // R7: full writes to every plain register, three patterns
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 14; i++)
                wr(full_list[i], pats[p+2] ^ (32'(full_list[i]) * 32'h0001_0001));
            for (int i = 0; i < 14; i++) begin
                rd(full_list[i], v);
                chk("R7", $sformatf("full write %03h", full_list[i]), v,
                    pats[p+2] ^ (32'(full_list[i]) * 32'h0001_0001));
            end
        end

        // R3 / R5: status window over pattern pairs
        for (int x = 0; x < 5; x++) begin
            for (int y = 0; y < 5; y++) begin
                wr(12'h300, pats[x]);
                rd(12'h100, v); chk("R3", "sstatus view", v, pats[x] & SMASK);
                wr(12'h100, pats[y]);
                exp = (pats[x] & ~SMASK) | (pats[y] & SMASK);
                rd(12'h300, v); chk("R5", "mstatus after sstatus write", v, exp);
            end
        end

        // R4 / R6: enable and pending windows over pattern pairs
        for (int x = 0; x < 5; x++) begin
            for (int y = 0; y < 5; y++) begin
                wr(12'h304, pats[x]);
                rd(12'h104, v); chk("R4", "sie view", v, pats[x] & IMASK);
                wr(12'h104, pats[y]);
                exp = (pats[x] & ~IMASK) | (pats[y] & IMASK);
                rd(12'h304, v); chk("R6", "mie after sie write", v, exp);
                wr(12'h344, pats[y]);
                rd(12'h144, v); chk("R4", "sip view", v, pats[y] & IMASK);
                wr(12'h144, pats[x]);
                exp = (pats[y] & ~IMASK) | (pats[x] & IMASK);
                rd(12'h344, v); chk("R6", "mip after sip write", v, exp);
            end
        end

        // R2: named bit positions
        for (int b = 1; b < 12; b += 2) begin
            wr(12'h304, 32'h1 << b);
            rd(12'h104, v);
            chk("R2", $sformatf("enable bit %0d in supervisor view", b), v,
                ((b % 4) == 1) ? (32'h1 << b) : 32'h0);
        end
        irq_timer = 1'b1; irq_ext = 1'b1;
        wr(12'h304, 32'h1 << 5); #1;
        chk("R2", "supervisor timer enable gives no machine timer req", {31'b0, mtimer_req}, 32'h0);
        wr(12'h304, 32'h1 << 9); #1;
        chk("R2", "supervisor ext enable gives no machine ext req", {31'b0, mext_req}, 32'h0);
        wr(12'h304, 32'h880); wr(12'h300, 32'h2); #1;
        chk("R2", "status bit 1 does not grant take", {31'b0, mtimer_take}, 32'h0);
        rd(12'h100, v); chk("R2", "supervisor enable visible", v, 32'h2);
        wr(12'h300, 32'h8);
        rd(12'h100, v); chk("R2", "machine enable hidden in view", v, 32'h0);
        irq_timer = 1'b0; irq_ext = 1'b0;

        // R11 / R12: all combinations
        for (int c = 0; c < 8; c++) begin
            wr(12'h304, (c & 1) ? 32'h880 : 32'h0);
            wr(12'h300, (c & 4) ? 32'h8 : 32'h0);
            irq_timer = (c & 2) != 0;
            irq_ext   = (c & 2) != 0;
            #1;
            exp = {31'b0, (c & 3) == 3};
            chk("R11", $sformatf("timer req combo %0d", c), {31'b0, mtimer_req}, exp);
            chk("R12", $sformatf("ext req combo %0d", c), {31'b0, mext_req}, exp);
            exp = {31'b0, c == 7};
            chk("R11", $sformatf("timer take combo %0d", c), {31'b0, mtimer_take}, exp);
            chk("R12", $sformatf("ext take combo %0d", c), {31'b0, mext_take}, exp);
        end
        irq_timer = 1'b0; irq_ext = 1'b0;

        // R9: writes to unknown numbers change nothing
        for (int i = 0; i < 14; i++) wr(full_list[i], 32'hC0DE_0000 | 32'(i));
        wr(12'h7FF, 32'hDEAD_BEEF);
        wr(12'h000, 32'hDEAD_BEEF);
        wr(12'h306, 32'hDEAD_BEEF);
        for (int i = 0; i < 14; i++) begin
            rd(full_list[i], v);
            chk("R9", $sformatf("unchanged %03h", full_list[i]), v, 32'hC0DE_0000 | 32'(i));
        end

        // R10: same-cycle read sees the old value
        wr(12'h340, 32'h1111_1111);
        @(negedge clk);
        csr_addr = 12'h340; csr_wdata = 32'h2222_2222; csr_we = 1'b1;
        #1 chk("R10", "read during write", csr_rdata, 32'h1111_1111);
        @(posedge clk);
        #1 chk("R10", "read after edge", csr_rdata, 32'h2222_2222);
        csr_we = 1'b0;

        // R1: reset again clears the shared registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(12'h304, v); chk("R1", "mie after second reset", v, 32'h0);
        rd(12'h305, v); chk("R1", "mtvec after second reset", v, 32'h8000_0020);

        summary();
    end

endmodule